// File: doc/BRIEF.md
# Three-Channel Alarm Comparator

This block holds three independent alarm channels that watch a free-running 52-bit tick count supplied by a separate counter. Each channel is configured through shadow inputs: a mode bit, a period and a 64-bit alarm time split into high and low words. None of these shadow values matter until the channel's load strobe is pulsed. At that point the channel captures them and arms in either one-shot or repeating operation.

A one-shot channel fires once, on the first enabled cycle in which the count has reached its absolute alarm time, and then goes quiet until it is loaded again. A repeating channel schedules its first alarm one period after the count seen at load time. After each firing it moves its alarm time forward by exactly one period from the previous alarm time, so the schedule does not drift.

Every firing produces a one-cycle event pulse that can be routed to other hardware. It also latches a raw status bit, which an interrupt enable masks to form a level interrupt. Software clears the status bit by writing a one to the clear input.

Each channel runs a small state machine with three states:
- CH_IDLE: not armed.
- CH_ONESHOT: armed with an absolute time.
- CH_REPEAT: armed with a period.

It has these transitions:
- Load with mode 0: any state goes to CH_ONESHOT.
- Load with mode 1: any state goes to CH_REPEAT.
- Match in CH_ONESHOT: goes to CH_IDLE.
- Match in CH_REPEAT: stays in CH_REPEAT and advances the alarm time.

Top module: `alarm_comparators`

## Requirements
- R1: After reset, `evt` and `irq` are all zero, and no channel produces an event before it has been loaded.
- R2: A load with mode bit 0 arms the channel with the alarm time {target_hi, target_lo}. An event bit rises in the cycle after the first cycle following the load in which `count` (zero-extended to 64 bits) is greater than or equal to that time. A time already passed therefore fires on the first cycle after the load.
- R3: A one-shot channel produces exactly one event per load. It produces no further events until it is loaded again.
- R4: A load with mode bit 1 and period P>0 schedules alarms at counts L+P, L+2P, L+3P, and so on, where L is the count during the load cycle. Each alarm raises the event bit in the following cycle.
- R5: Changing the shadow mode, period or target inputs without a load strobe has no effect on the events of an armed channel.
- R6: While `work_en` of a channel is 0 it produces no events. When it is raised after a one-shot alarm time has passed, the channel fires in the cycle after the first enabled cycle.
- R7: Each event sets the channel's raw status bit, which holds until cleared. `irq` equals raw status AND `int_en`, so masking and unmasking does not lose a pending status.
- R8: A 1 on `int_clr` clears the raw status at the next clock edge. A match in the same cycle wins, and the status stays set.
- R9: A load strobe in the same cycle as a match suppresses that match: no event is produced, and the channel re-arms with the new values.
- R10: The three channels are independent. Channel i uses bit i of every per-channel vector and the slice [i*W +: W] of every packed field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count | input | 52 | Current tick count from the external counter |
| sh_mode | input | 3 | Shadow mode per channel: 0 one-shot, 1 repeating |
| sh_period | input | 78 | Shadow period per channel, 26 bits each, in ticks |
| sh_target_hi | input | 96 | Shadow alarm time upper word per channel |
| sh_target_lo | input | 96 | Shadow alarm time lower word per channel |
| load | input | 3 | Per-channel strobe that applies the shadow values |
| work_en | input | 3 | Per-channel compare enable |
| int_en | input | 3 | Per-channel interrupt enable |
| int_clr | input | 3 | Per-channel write-one-to-clear of the raw status |
| evt | output | 3 | One-cycle event pulse per channel |
| irq | output | 3 | Level interrupt per channel |

## Verification
The in-line assertions check four rules on every cycle:
- An idle or disabled channel never pulses.
- A load always wins over a coincident match.
- A repeating match advances the alarm time by exactly the stored period.
- The raw status holds until it is cleared, and every event finds it set.

Only the bench's scenarios can show the timing of events against arithmetic expectations: the cycle of a one-shot firing, the L+kP schedule for several periods, and the late firing after enable. The bench scenarios also show that shadow changes without a load are ignored, and that set wins over clear on the interrupt path.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_ONESHOT = 2'd1,
        CH_REPEAT  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_pkg::*;
#(
    parameter int CNT_W = 52,
    parameter int PER_W = 26,
    parameter int TGT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             sh_mode,
    input  logic [PER_W-1:0] sh_period,
    input  logic [TGT_W-1:0] sh_target,
    input  logic             load,
    input  logic             work_en,
    output logic             match_now,
    output logic             fire_q
);
    localparam int CPAD = TGT_W - CNT_W;
    localparam int PPAD = TGT_W - PER_W;

    ch_state_e        st_q, st_n;
    logic [TGT_W-1:0] alarm_q, alarm_n;
    logic [PER_W-1:0] period_q, period_n;
    logic [TGT_W-1:0] cnt_ext;
    logic             hit;

    assign cnt_ext = {{CPAD{1'b0}}, count};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CH_IDLE;
            alarm_q  <= '0;
            period_q <= '0;
            fire_q   <= 1'b0;
        end else begin
            st_q     <= st_n;
            alarm_q  <= alarm_n;
            period_q <= period_n;
            fire_q   <= match_now;
        end
    end

    // Outputs: compare result and qualified match
    always_comb begin
        hit       = work_en && (st_q != CH_IDLE) && (cnt_ext >= alarm_q);
        match_now = hit && !load;
    end

    // Next state
    always_comb begin
        st_n     = st_q;
        alarm_n  = alarm_q;
        period_n = period_q;
        if (load) begin
            period_n = sh_period;
            if (sh_mode) begin
                st_n    = CH_REPEAT;
                alarm_n = cnt_ext + {{PPAD{1'b0}}, sh_period};
            end else begin
                st_n    = CH_ONESHOT;
                alarm_n = sh_target;
            end
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    st_n = CH_IDLE;
                end
                CH_ONESHOT: begin
                    if (hit) st_n = CH_IDLE;
                end
                CH_REPEAT: begin
                    if (hit) alarm_n = alarm_q + {{PPAD{1'b0}}, period_q};
                end
                default: st_n = CH_IDLE;
            endcase
        end
    end

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE && !load) |=> !fire_q);

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !work_en |=> !fire_q);

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !fire_q);

    assert_period_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_REPEAT && match_now) |=>
            (alarm_q == $past(alarm_q) + {{PPAD{1'b0}}, $past(period_q)}));
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic raw_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)   raw_q <= 1'b0;
        else if (set) raw_q <= 1'b1;
        else if (clr) raw_q <= 1'b0;
    end

    assign irq = raw_q & en;

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !raw_q);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q && !clr) |=> raw_q);
endmodule

// File: rtl/alarm_comparators.sv
module alarm_comparators #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 52,
    parameter int PER_W  = 26,
    parameter int HALF_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       count,
    input  logic [NUM_CH-1:0]      sh_mode,
    input  logic [NUM_CH*PER_W-1:0] sh_period,
    input  logic [NUM_CH*HALF_W-1:0] sh_target_hi,
    input  logic [NUM_CH*HALF_W-1:0] sh_target_lo,
    input  logic [NUM_CH-1:0]      load,
    input  logic [NUM_CH-1:0]      work_en,
    input  logic [NUM_CH-1:0]      int_en,
    input  logic [NUM_CH-1:0]      int_clr,
    output logic [NUM_CH-1:0]      evt,
    output logic [NUM_CH-1:0]      irq
);
    localparam int TGT_W = 2 * HALF_W;

    logic [NUM_CH-1:0] match_now;
    logic [NUM_CH-1:0] raw;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        alarm_channel #(
            .CNT_W (CNT_W),
            .PER_W (PER_W),
            .TGT_W (TGT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (count),
            .sh_mode   (sh_mode[i]),
            .sh_period (sh_period[i*PER_W +: PER_W]),
            .sh_target ({sh_target_hi[i*HALF_W +: HALF_W], sh_target_lo[i*HALF_W +: HALF_W]}),
            .load      (load[i]),
            .work_en   (work_en[i]),
            .match_now (match_now[i]),
            .fire_q    (evt[i])
        );

        alarm_status u_stat (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (match_now[i]),
            .clr   (int_clr[i]),
            .en    (int_en[i]),
            .raw_q (raw[i]),
            .irq   (irq[i])
        );

        assert_evt_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |-> raw[i]);
    end
endmodule

// File: tb/alarm_comparators_test.sv
`timescale 1ns/1ps
module alarm_comparators_test;
    localparam int NCH = 3;
    localparam int CW  = 52;
    localparam int PW  = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     count = '0;
    logic [NCH-1:0]    sh_mode = '0;
    logic [NCH*PW-1:0] sh_period = '0;
    logic [NCH*32-1:0] sh_target_hi = '0;
    logic [NCH*32-1:0] sh_target_lo = '0;
    logic [NCH-1:0]    load = '0;
    logic [NCH-1:0]    work_en = '0;
    logic [NCH-1:0]    int_en = '0;
    logic [NCH-1:0]    int_clr = '0;
    logic [NCH-1:0]    evt;
    logic [NCH-1:0]    irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    longint last_c;
    logic [NCH-1:0] seen_evt, seen_irq;
    bit     m_mode [NCH];
    longint m_t [NCH];
    longint m_p [NCH];
    longint m_cl [NCH];

    always #4 clk = ~clk;

    alarm_comparators uut (
        .clk(clk), .rst_n(rst_n), .count(count), .sh_mode(sh_mode),
        .sh_period(sh_period), .sh_target_hi(sh_target_hi), .sh_target_lo(sh_target_lo),
        .load(load), .work_en(work_en), .int_en(int_en), .int_clr(int_clr),
        .evt(evt), .irq(irq)
    );

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic check(string tag, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (count %0d)", tag, act, exp, last_c);
        end
    endtask

    task automatic step();
        last_c = longint'(count);
        @(posedge clk); #2;
        seen_evt = evt;
        seen_irq = irq;
        load = '0;
        int_clr = '0;
        count = count + 1'b1;
    endtask

    task automatic set_shadow(int ch, bit md, longint t, longint p);
        logic [63:0] tv;
        tv = t;
        sh_mode[ch] = md;
        sh_target_hi[ch*32 +: 32] = tv[63:32];
        sh_target_lo[ch*32 +: 32] = tv[31:0];
        sh_period[ch*PW +: PW] = PW'(p);
    endtask

    task automatic arm(int ch, bit md, longint t, longint p);
        set_shadow(ch, md, t, p);
        load[ch] = 1'b1;
        m_mode[ch] = md; m_t[ch] = t; m_p[ch] = p; m_cl[ch] = longint'(count);
    endtask

    function automatic bit exp_evt(int ch, longint c);
        longint first;
        if (c <= m_cl[ch]) return 1'b0;
        if (!m_mode[ch]) begin
            first = (m_t[ch] > m_cl[ch] + 1) ? m_t[ch] : m_cl[ch] + 1;
            return c == first;
        end
        return ((c - m_cl[ch]) % m_p[ch]) == 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        report();
    end

    initial begin
        int ones [NCH];
        longint cl;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 evt in reset", evt, 0);
        check("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        count = 52'd1000;
        work_en = '1;
        int_en = '1;
        for (int k = 0; k < 10; k++) begin
            step();
            check("R1 no event before load", seen_evt, 0);
            check("R1 no irq before load", seen_irq, 0);
        end
        int_en = '0;

        // Sweep A: one-shot targets, R2 R3 R5 R10
        for (int tr = 0; tr < 8; tr++) begin
            cl = longint'(count);
            arm(0, 1'b0, cl + tr, 0);
            arm(1, 1'b0, cl + tr + 3, 0);
            arm(2, 1'b0, cl - 5 + tr, 0);
            for (int ch = 0; ch < NCH; ch++) ones[ch] = 0;
            for (int k = 0; k < 20; k++) begin
                if (k == 2) begin
                    // R5: shadow change without load
                    for (int ch = 0; ch < NCH; ch++) set_shadow(ch, 1'b1, longint'(count) + 1, 1);
                end
                step();
                for (int ch = 0; ch < NCH; ch++) begin
                    check("R2 R5 R10 one-shot event", seen_evt[ch], exp_evt(ch, last_c));
                    ones[ch] += int'(seen_evt[ch]);
                end
            end
            for (int ch = 0; ch < NCH; ch++) check("R3 single event per load", ones[ch], 1);
        end

        // Sweep B: repeating, R4 R5
        for (int p = 1; p <= 4; p++) begin
            for (int ch = 0; ch < NCH; ch++) arm(ch, 1'b1, 0, p + ch);
            for (int k = 0; k < 30; k++) begin
                if (k == 5) begin
                    for (int ch = 0; ch < NCH; ch++) set_shadow(ch, 1'b0, 0, 7);
                end
                step();
                for (int ch = 0; ch < NCH; ch++)
                    check("R4 R5 periodic schedule", seen_evt[ch], exp_evt(ch, last_c));
            end
        end

        // Mixed modes, R10
        cl = longint'(count);
        arm(0, 1'b0, cl + 4, 0);
        arm(1, 1'b1, 0, 3);
        arm(2, 1'b0, cl + 7, 0);
        for (int k = 0; k < 20; k++) begin
            step();
            for (int ch = 0; ch < NCH; ch++)
                check("R10 mixed channels", seen_evt[ch], exp_evt(ch, last_c));
        end

        // Park all channels far in the future
        for (int ch = 0; ch < NCH; ch++) arm(ch, 1'b0, 64'h0008_0000_0000_0000, 0);
        step();

        // R6: work enable gating and late fire
        cl = longint'(count);
        arm(0, 1'b0, cl + 3, 0);
        work_en = 3'b110;
        step();
        for (int k = 0; k < 8; k++) begin
            step();
            check("R6 disabled channel silent", seen_evt, 0);
        end
        work_en = 3'b111;
        step();
        check("R6 late fire on enable", seen_evt, 3'b001);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R3 no refire after one-shot", seen_evt, 0);
        end

        // R7 R8: status and interrupt
        int_en = '0;
        cl = longint'(count);
        arm(1, 1'b0, cl + 2, 0);
        step();
        step();
        check("R2 not yet", seen_evt, 0);
        step();
        check("R2 fires at target", seen_evt, 3'b010);
        check("R7 masked irq", seen_irq, 0);
        int_en = 3'b010;
        #1;
        check("R7 unmask shows pending", irq, 3'b010);
        step();
        check("R7 status holds", seen_irq, 3'b010);
        int_clr = 3'b010;
        step();
        check("R8 clear drops irq", seen_irq, 0);

        int_en = 3'b110;
        cl = longint'(count);
        arm(2, 1'b0, cl + 3, 0);
        step();
        step();
        step();
        int_clr = 3'b100;
        step();
        check("R8 match event with clear", seen_evt, 3'b100);
        check("R8 set wins over clear", seen_irq, 3'b100);
        int_clr = 3'b100;
        step();
        check("R8 later clear works", seen_irq, 0);

        // R9: load in match cycle
        int_en = '0;
        cl = longint'(count);
        arm(0, 1'b0, cl + 2, 0);
        step();
        step();
        check("R9 before match", seen_evt, 0);
        arm(0, 1'b0, 64'h0008_0000_0000_0000, 0);
        step();
        check("R9 load suppresses match", seen_evt, 0);
        for (int k = 0; k < 5; k++) begin
            step();
            check("R9 re-armed channel silent", seen_evt, 0);
        end

        report();
    end
endmodule